// File: doc/BRIEF.md
# SD/MMC Command-Line Engine

This block drives the single-bit command line of an SD or MMC card. The controller presents a 6-bit command index and a 32-bit argument, then raises one-cycle launch strobes. Each strobe sets its own busy bit, and hardware clears that bit when the phase is over. One strobe sends a command frame. Two more wait for a 48-bit or 136-bit response. The last two run a free clock burst: 74 clocks before the first command after power-up, or 8 clocks after a sequence so that the card can finish its work. The card clock itself is made elsewhere. The engine advances one line bit per `clk` cycle and raises `card_clk_run` in every cycle in which the card clock must toggle.

The block builds the command frame and appends the CRC7. It captures a response, checks that response's CRC7 and reports the result. Some response types carry no valid CRC7, but they go through the same check, so they raise the error flag. The controller ignores that flag for those types and clears it. The DAT0 level seen at the end of an 8-clock burst is kept, so that card busy can be polled. An abort input stops whatever phase is running.

Top module: `sd_cmd_engine`

## Requirements
- R1: After `set_cmd`, the engine drives `cmd_oe` high for 48 consecutive cycles and places one frame bit per cycle on `cmd_out`, most significant bit first. The frame is {0, 1, index[5:0], argument[31:0], CRC7[6:0], 1}, where CRC7 uses x^7+x^3+1 from a zero start over the first 40 frame bits. The first bit appears in the second cycle after the strobe, and `cmd_busy` drops in the cycle after the last bit.
- R2: Outside the command phase, `cmd_oe` is low and `cmd_out` is high.
- R3: A short response (`set_rsp`) begins at the first sampled 0 on `cmd_in`. Exactly 48 bits are taken, counting the start bit. When the end bit has been taken, `rsp_busy` is low and `rsp_word` holds response bits 39:8.
- R4: A long response (`set_rsp_long`) takes 136 bits. When it is done, `rsp_long` holds response bits 127:0, and `rsp_long_busy` is low.
- R5: At the end of each response, `crc_pass` shows whether the computed CRC7 equals received bits 7:1. The computed CRC7 covers bits 47:8 of a short response and bits 127:8 of a long one. A mismatch sets the sticky `crc_err`. A later good response does not clear `crc_err`; only `crc_err_clr` does, and a new mismatch in the same cycle wins over the clear.
- R6: If 64 sampled cycles of the response wait pass with no start bit, `rsp_tmo` is set and the response busy bit clears. A start bit in the 64th sampled cycle is still accepted. `tmo_clr` clears `rsp_tmo`.
- R7: `set_pwr_clk` gives exactly 74 cycles of `card_clk_run`, with `cmd_out` high and `cmd_oe` low, and then `pwr_busy` clears.
- R8: `set_tail_clk` gives exactly 8 cycles of `card_clk_run`. `dat0_level` then holds the `dat0_in` value sampled on the final burst clock edge, and `tail_busy` clears.
- R9: Pending phases run one at a time. The power burst goes first, then the command, then the response, then the 8-clock burst.
- R10: `ctl_abort` clears every busy bit and stops all line activity in the next cycle, and it leaves the response flags and captured data unchanged.
- R11: After reset, every busy bit and every flag is 0, and the line is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock; one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| set_cmd | input | 1 | Launch command transmit |
| set_rsp | input | 1 | Launch 48-bit response receive |
| set_rsp_long | input | 1 | Launch 136-bit response receive |
| set_pwr_clk | input | 1 | Launch 74-clock burst |
| set_tail_clk | input | 1 | Launch 8-clock burst |
| ctl_abort | input | 1 | Abort all phases |
| crc_err_clr | input | 1 | Clear CRC error flag |
| tmo_clr | input | 1 | Clear timeout flag |
| cmd_in | input | 1 | Sampled command line from card |
| dat0_in | input | 1 | Sampled DAT0 line |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| card_clk_run | output | 1 | Card clock must toggle this cycle |
| cmd_busy | output | 1 | Command transmit pending or running |
| rsp_busy | output | 1 | Short response pending or running |
| rsp_long_busy | output | 1 | Long response pending or running |
| pwr_busy | output | 1 | 74-clock burst pending or running |
| tail_busy | output | 1 | 8-clock burst pending or running |
| crc_pass | output | 1 | Last response CRC7 matched |
| crc_err | output | 1 | Sticky CRC7 mismatch flag |
| rsp_tmo | output | 1 | Sticky response timeout flag |
| dat0_level | output | 1 | DAT0 level at end of last 8-clock burst |
| rsp_word | output | 32 | Short response bits 39:8 |
| rsp_long | output | 128 | Long response bits 127:0 |

## Verification
Every result is due at a fixed cycle counted from the launch edge. The first command bit appears two edges after the strobe edge. Response results appear on the edge that samples the end bit. A timeout is reported on the 64th sampled wait edge. Burst busy bits drop one edge after the last burst clock. The bench moves its inputs and reads the outputs only on falling edges, and it counts falling edges from the strobe to reach each of these points. Responses are driven with start delays from 1 to 64 cycles, and a run with no start bit checks the boundary cycle on both sides.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    localparam int IDX_W   = 6;
    localparam int ARG_W   = 32;
    localparam int CRC_W   = 7;
    localparam int FRAME_W = 2 + IDX_W + ARG_W + CRC_W + 1;
    localparam int BODY_W  = FRAME_W - CRC_W - 1;
    localparam int LONG_W  = 136;
    localparam int CAP_W   = 128;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SEND,
        PH_RECV,
        PH_CLKS
    } phase_t;

    typedef struct packed {
        logic             start;
        logic             dir;
        logic [IDX_W-1:0] idx;
        logic [ARG_W-1:0] arg;
        logic [CRC_W-1:0] crc;
        logic             stop;
    } cmd_frame_t;

    typedef struct packed {
        logic cmd;
        logic rsp;
        logic rsp_long;
        logic pwr;
        logic tail;
    } launch_t;

    // one serial step of x^7 + x^3 + 1
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic d);
        logic fb;
        fb = d ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic cmd_frame_t make_frame(input logic [IDX_W-1:0] idx, input logic [ARG_W-1:0] arg);
        cmd_frame_t        f;
        logic [BODY_W-1:0] body;
        logic [CRC_W-1:0]  c;
        f.start = 1'b0;
        f.dir   = 1'b1;
        f.idx   = idx;
        f.arg   = arg;
        f.stop  = 1'b1;
        body    = {f.start, f.dir, idx, arg};
        c       = '0;
        for (int i = BODY_W - 1; i >= 0; i--) begin
            c = crc7_step(c, body[i]);
        end
        f.crc = c;
        return f;
    endfunction

endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
    import sd_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             kill,
    input  logic             start,
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    output logic             active,
    output logic             done,
    output logic             bit_o
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   cnt;

    assign done  = active && (cnt == LAST);
    assign bit_o = sh[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            active <= 1'b0;
            cnt    <= '0;
            sh     <= '1;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            sh     <= make_frame(idx, arg);
        end else if (active) begin
            sh  <= {sh[FRAME_W-2:0], 1'b1};
            cnt <= cnt + 1'b1;
            if (done) begin
                active <= 1'b0;
            end
        end
    end

    // R1
    tx_start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !kill) |=> (active && !bit_o));

endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
    import sd_cmd_pkg::*;
#(
    parameter int TMO = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kill,
    input  logic             start,
    input  logic             long_sel,
    input  logic             din,
    output logic             active,
    output logic             done,
    output logic             tmo,
    output logic             crc_good,
    output logic [CAP_W-1:0] cap
);
    localparam int SHORT_N = FRAME_W - 1;
    localparam int LONG_N  = LONG_W - 1;
    localparam int CNT_W   = $clog2(LONG_N + 1);
    localparam int WT_W    = $clog2(TMO);
    localparam logic [CNT_W-1:0] S_LAST   = CNT_W'(SHORT_N - 1);
    localparam logic [CNT_W-1:0] L_LAST   = CNT_W'(LONG_N - 1);
    localparam logic [CNT_W-1:0] S_CRC_HI = CNT_W'(SHORT_N - 1 - 8);
    localparam logic [CNT_W-1:0] L_CRC_LO = CNT_W'(LONG_N - 1 - 127);
    localparam logic [CNT_W-1:0] L_CRC_HI = CNT_W'(LONG_N - 1 - 8);
    localparam logic [WT_W-1:0]  W_LAST   = WT_W'(TMO - 1);

    logic             started;
    logic             is_long;
    logic [WT_W-1:0]  wcnt;
    logic [CNT_W-1:0] bcnt;
    logic [CAP_W-2:0] sh;
    logic [CRC_W-1:0] crc;
    logic [CNT_W-1:0] last_b;
    logic             crc_on;

    assign last_b   = is_long ? L_LAST : S_LAST;
    assign crc_on   = is_long ? ((bcnt >= L_CRC_LO) && (bcnt <= L_CRC_HI)) : (bcnt <= S_CRC_HI);
    assign done     = active && started && (bcnt == last_b);
    assign tmo      = active && !started && din && (wcnt == W_LAST);
    assign crc_good = (crc == sh[CRC_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            started <= 1'b0;
            is_long <= 1'b0;
            wcnt    <= '0;
            bcnt    <= '0;
            sh      <= '0;
            crc     <= '0;
            cap     <= '0;
        end else if (kill) begin
            active  <= 1'b0;
            started <= 1'b0;
        end else if (start) begin
            active  <= 1'b1;
            started <= 1'b0;
            is_long <= long_sel;
            wcnt    <= '0;
            bcnt    <= '0;
            crc     <= '0;
        end else if (active) begin
            if (!started) begin
                if (!din) begin
                    started <= 1'b1;
                end else if (tmo) begin
                    active <= 1'b0;
                end else begin
                    wcnt <= wcnt + 1'b1;
                end
            end else begin
                sh   <= {sh[CAP_W-3:0], din};
                bcnt <= bcnt + 1'b1;
                if (crc_on) begin
                    crc <= crc7_step(crc, din);
                end
                if (done) begin
                    active  <= 1'b0;
                    started <= 1'b0;
                    cap     <= {sh, din};
                end
            end
        end
    end

endmodule

// File: rtl/sd_cmd_burst.sv
module sd_cmd_burst #(
    parameter int N_LONG  = 74,
    parameter int N_SHORT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic start,
    input  logic sel_long,
    output logic active,
    output logic done,
    output logic is_long
);
    localparam int CW = $clog2(N_LONG);
    localparam logic [CW-1:0] LAST_L = CW'(N_LONG - 1);
    localparam logic [CW-1:0] LAST_S = CW'(N_SHORT - 1);

    logic [CW-1:0] cnt;

    assign done = active && (cnt == (is_long ? LAST_L : LAST_S));

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            active  <= 1'b0;
            is_long <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            active  <= 1'b1;
            is_long <= sel_long;
            cnt     <= '0;
        end else if (active) begin
            cnt <= cnt + 1'b1;
            if (done) begin
                active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int TMO_CLKS  = 64,
    parameter int PWR_CLKS  = 74,
    parameter int TAIL_CLKS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [ARG_W-1:0]   cmd_arg,
    input  logic               set_cmd,
    input  logic               set_rsp,
    input  logic               set_rsp_long,
    input  logic               set_pwr_clk,
    input  logic               set_tail_clk,
    input  logic               ctl_abort,
    input  logic               crc_err_clr,
    input  logic               tmo_clr,
    input  logic               cmd_in,
    input  logic               dat0_in,
    output logic               cmd_out,
    output logic               cmd_oe,
    output logic               card_clk_run,
    output logic               cmd_busy,
    output logic               rsp_busy,
    output logic               rsp_long_busy,
    output logic               pwr_busy,
    output logic               tail_busy,
    output logic               crc_pass,
    output logic               crc_err,
    output logic               rsp_tmo,
    output logic               dat0_level,
    output logic [ARG_W-1:0]   rsp_word,
    output logic [CAP_W-1:0]   rsp_long
);
    phase_t  ph;
    launch_t en;

    logic tx_act, tx_done, tx_bit;
    logic rx_act, rx_done, rx_tmo, rx_good;
    logic b_act, b_done, b_long;
    logic pick_tx, pick_rx, pick_b;
    logic [CAP_W-1:0] cap;

    assign pick_tx = (ph == PH_IDLE) && !ctl_abort && !en.pwr && en.cmd;
    assign pick_rx = (ph == PH_IDLE) && !ctl_abort && !en.pwr && !en.cmd && (en.rsp || en.rsp_long);
    assign pick_b  = (ph == PH_IDLE) && !ctl_abort &&
                     (en.pwr || (!en.cmd && !en.rsp && !en.rsp_long && en.tail));

    sd_cmd_tx u_tx (
        .clk(clk), .rst(rst), .kill(ctl_abort), .start(pick_tx),
        .idx(cmd_idx), .arg(cmd_arg),
        .active(tx_act), .done(tx_done), .bit_o(tx_bit)
    );

    sd_cmd_rx #(.TMO(TMO_CLKS)) u_rx (
        .clk(clk), .rst(rst), .kill(ctl_abort), .start(pick_rx),
        .long_sel(en.rsp_long), .din(cmd_in),
        .active(rx_act), .done(rx_done), .tmo(rx_tmo),
        .crc_good(rx_good), .cap(cap)
    );

    sd_cmd_burst #(.N_LONG(PWR_CLKS), .N_SHORT(TAIL_CLKS)) u_burst (
        .clk(clk), .rst(rst), .kill(ctl_abort), .start(pick_b),
        .sel_long(en.pwr), .active(b_act), .done(b_done), .is_long(b_long)
    );

    assign cmd_oe        = tx_act;
    assign cmd_out       = tx_act ? tx_bit : 1'b1;
    assign card_clk_run  = tx_act || rx_act || b_act;
    assign cmd_busy      = en.cmd;
    assign rsp_busy      = en.rsp;
    assign rsp_long_busy = en.rsp_long;
    assign pwr_busy      = en.pwr;
    assign tail_busy     = en.tail;
    assign rsp_word      = cap[39:8];
    assign rsp_long      = cap;

    // phase sequencing and self-clearing launch bits
    always_ff @(posedge clk) begin
        if (rst || ctl_abort) begin
            ph <= PH_IDLE;
            en <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (pick_tx)      ph <= PH_SEND;
                    else if (pick_rx) ph <= PH_RECV;
                    else if (pick_b)  ph <= PH_CLKS;
                end
                PH_SEND: if (tx_done) ph <= PH_IDLE;
                PH_RECV: if (rx_done || rx_tmo) ph <= PH_IDLE;
                PH_CLKS: if (b_done) ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
            en.cmd      <= (en.cmd      && !tx_done)               || set_cmd;
            en.rsp      <= (en.rsp      && !(rx_done || rx_tmo))   || set_rsp;
            en.rsp_long <= (en.rsp_long && !(rx_done || rx_tmo))   || set_rsp_long;
            en.pwr      <= (en.pwr      && !(b_done && b_long))    || set_pwr_clk;
            en.tail     <= (en.tail     && !(b_done && !b_long))   || set_tail_clk;
        end
    end

    // status flags
    always_ff @(posedge clk) begin
        if (rst) begin
            crc_pass   <= 1'b0;
            crc_err    <= 1'b0;
            rsp_tmo    <= 1'b0;
            dat0_level <= 1'b0;
        end else begin
            if (rx_done && !ctl_abort) begin
                crc_pass <= rx_good;
            end
            crc_err <= (crc_err && !crc_err_clr) || (rx_done && !rx_good && !ctl_abort);
            rsp_tmo <= (rsp_tmo && !tmo_clr) || (rx_tmo && !ctl_abort);
            if (b_done && !b_long && !ctl_abort) begin
                dat0_level <= dat0_in;
            end
        end
    end

    // R3
    rsp_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !set_rsp && !set_rsp_long && !ctl_abort) |=> (!rsp_busy && !rsp_long_busy));

    // R6
    tmo_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_tmo && !ctl_abort && !set_rsp && !set_rsp_long) |=> (rsp_tmo && !rsp_busy && !rsp_long_busy));

    // R9
    one_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_act, rx_act, b_act}));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_abort |=> (!card_clk_run && !cmd_busy && !rsp_busy && !rsp_long_busy && !pwr_busy && !tail_busy));

    // R7
    pwr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (b_act && b_long) |-> (cmd_out && !cmd_oe));

endmodule

// File: tb/sd_cmd_engine_test.sv
module sd_cmd_engine_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [5:0]   cmd_idx = '0;
    logic [31:0]  cmd_arg = '0;
    logic         set_cmd = 0, set_rsp = 0, set_rsp_long = 0, set_pwr_clk = 0, set_tail_clk = 0;
    logic         ctl_abort = 0, crc_err_clr = 0, tmo_clr = 0;
    logic         cmd_in = 1'b1, dat0_in = 1'b0;
    logic         cmd_out, cmd_oe, card_clk_run;
    logic         cmd_busy, rsp_busy, rsp_long_busy, pwr_busy, tail_busy;
    logic         crc_pass, crc_err, rsp_tmo, dat0_level;
    logic [31:0]  rsp_word;
    logic [127:0] rsp_long;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    sd_cmd_engine uut (
        .clk(clk), .rst(rst), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .set_cmd(set_cmd), .set_rsp(set_rsp), .set_rsp_long(set_rsp_long),
        .set_pwr_clk(set_pwr_clk), .set_tail_clk(set_tail_clk),
        .ctl_abort(ctl_abort), .crc_err_clr(crc_err_clr), .tmo_clr(tmo_clr),
        .cmd_in(cmd_in), .dat0_in(dat0_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .card_clk_run(card_clk_run),
        .cmd_busy(cmd_busy), .rsp_busy(rsp_busy), .rsp_long_busy(rsp_long_busy),
        .pwr_busy(pwr_busy), .tail_busy(tail_busy),
        .crc_pass(crc_pass), .crc_err(crc_err), .rsp_tmo(rsp_tmo),
        .dat0_level(dat0_level), .rsp_word(rsp_word), .rsp_long(rsp_long)
    );

    task automatic chk(input string req, input logic [135:0] act, input logic [135:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [119:0] v, input int n);
        logic [6:0] r;
        logic       m;
        r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            m = v[i] ^ r[6];
            r = {r[5:0], 1'b0};
            if (m) r = r ^ 7'b0001001;
        end
        return r;
    endfunction

    function automatic logic [47:0] ref_cmd(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] c;
        c = {2'b01, idx, arg};
        return {c, ref_crc({80'b0, c}, 40), 1'b1};
    endfunction

    function automatic logic [47:0] ref_short(input logic [5:0] idx, input logic [31:0] w, input logic bad_crc);
        logic [39:0] c;
        c = {2'b00, idx, w};
        return {c, ref_crc({80'b0, c}, 40) ^ {6'b0, bad_crc}, 1'b1};
    endfunction

    function automatic logic [135:0] ref_long(input logic [119:0] body);
        return {8'h3F, body, ref_crc(body, 120), 1'b1};
    endfunction

    task automatic launch(input logic c, input logic r, input logic l, input logic p, input logic t);
        {set_cmd, set_rsp, set_rsp_long, set_pwr_clk, set_tail_clk} = {c, r, l, p, t};
        @(negedge clk);
        {set_cmd, set_rsp, set_rsp_long, set_pwr_clk, set_tail_clk} = '0;
    endtask

    task automatic send_and_check(input logic [5:0] idx, input logic [31:0] arg);
        logic [47:0] f;
        int          miss;
        f = ref_cmd(idx, arg);
        cmd_idx = idx;
        cmd_arg = arg;
        miss = 0;
        launch(1, 0, 0, 0, 0);
        for (int k = 47; k >= 0; k--) begin
            @(negedge clk);
            if ({cmd_oe, cmd_out} !== {1'b1, f[k]}) miss++;
        end
        chk("R1 frame bits", miss, 0);
        @(negedge clk);
        chk("R1 busy cleared", cmd_busy, 0);
        chk("R2 line idle", {cmd_oe, cmd_out}, 2'b01);
    endtask

    task automatic drive_rsp(input logic [135:0] f, input int len, input logic lng, input int dly);
        launch(0, !lng, lng, 0, 0);
        repeat (dly) @(negedge clk);
        for (int i = len - 1; i >= 0; i--) begin
            cmd_in = f[i];
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    task automatic pulse_abort();
        ctl_abort = 1'b1;
        @(negedge clk);
        ctl_abort = 1'b0;
    endtask

    initial begin
        int unsigned seed_use;
        logic        exp_err;
        seed_use = $urandom(32'd7321);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 busy bits", {cmd_busy, rsp_busy, rsp_long_busy, pwr_busy, tail_busy}, 0);
        chk("R11 flags", {crc_pass, crc_err, rsp_tmo, dat0_level}, 0);
        chk("R11 line", {cmd_oe, cmd_out, card_clk_run}, 3'b010);

        // R7 power-up burst
        begin
            int n;
            int noisy;
            n = 0;
            noisy = 0;
            launch(0, 0, 0, 1, 0);
            repeat (80) begin
                @(negedge clk);
                if (card_clk_run) n++;
                if (cmd_oe || !cmd_out) noisy++;
            end
            chk("R7 burst length", n, 74);
            chk("R7 line high", noisy, 0);
            chk("R7 busy cleared", pwr_busy, 0);
        end

        // R1 directed and random commands
        send_and_check(6'd0, 32'h0);
        send_and_check(6'd8, 32'h0000_0155);
        send_and_check(6'h3F, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) begin
            send_and_check(6'($urandom), $urandom);
        end

        // R3 / R5 short responses
        drive_rsp({88'b0, ref_short(6'd3, 32'hCAFE_0123, 1'b0)}, 48, 0, 1);
        chk("R3 word", rsp_word, 32'hCAFE_0123);
        chk("R3 busy cleared", rsp_busy, 0);
        chk("R5 pass", {crc_pass, crc_err}, 2'b10);

        drive_rsp({88'b0, ref_short(6'h3F, 32'h80FF_8000, 1'b1)}, 48, 0, 64);
        chk("R3 late start word", rsp_word, 32'h80FF_8000);
        chk("R5 bad crc", {crc_pass, crc_err}, 2'b01);

        drive_rsp({88'b0, ref_short(6'd7, 32'h1234_5678, 1'b0)}, 48, 0, 5);
        chk("R5 sticky err", {crc_pass, crc_err}, 2'b11);

        crc_err_clr = 1'b1;
        @(negedge clk);
        crc_err_clr = 1'b0;
        chk("R5 clear", crc_err, 0);

        exp_err = 1'b0;
        for (int i = 0; i < 10; i++) begin
            logic [31:0] w;
            logic        corrupt;
            w = $urandom;
            corrupt = ($urandom % 3) == 0;
            exp_err = exp_err | corrupt;
            drive_rsp({88'b0, ref_short(6'($urandom), w, corrupt)}, 48, 0, 1 + int'($urandom % 64));
            chk("R3 random word", rsp_word, w);
            chk("R5 random crc", {crc_pass, crc_err}, {!corrupt, exp_err});
        end
        crc_err_clr = 1'b1;
        @(negedge clk);
        crc_err_clr = 1'b0;

        // R4 long responses
        for (int i = 0; i < 4; i++) begin
            logic [119:0] body;
            logic [135:0] f;
            body = {$urandom, $urandom, $urandom, 24'($urandom)};
            f = ref_long(body);
            drive_rsp(f, 136, 1, 1 + i * 7);
            chk("R4 long data", rsp_long, f[127:0]);
            chk("R4 busy cleared", rsp_long_busy, 0);
            chk("R5 long crc", {crc_pass, crc_err}, 2'b10);
        end

        // R6 timeout boundary
        launch(0, 1, 0, 0, 0);
        repeat (64) @(negedge clk);
        chk("R6 not yet", {rsp_tmo, rsp_busy}, 2'b01);
        @(negedge clk);
        chk("R6 timeout", {rsp_tmo, rsp_busy, card_clk_run}, 3'b100);
        tmo_clr = 1'b1;
        @(negedge clk);
        tmo_clr = 1'b0;
        chk("R6 clear", rsp_tmo, 0);

        // R8 tail burst and DAT0 capture
        dat0_in = 1'b0;
        launch(0, 0, 0, 0, 1);
        repeat (7) @(negedge clk);
        chk("R8 still running", {tail_busy, card_clk_run}, 2'b11);
        @(negedge clk);
        dat0_in = 1'b1;
        @(negedge clk);
        chk("R8 dat0 high", {dat0_level, tail_busy, card_clk_run}, 3'b100);
        launch(0, 0, 0, 0, 1);
        repeat (8) @(negedge clk);
        dat0_in = 1'b0;
        @(negedge clk);
        chk("R8 dat0 low", {dat0_level, tail_busy}, 2'b00);

        // R9 ordering
        begin
            int viol;
            viol = 0;
            cmd_idx = 6'd12;
            cmd_arg = 32'h0;
            launch(1, 0, 0, 1, 1);
            while (pwr_busy) begin
                if (cmd_oe) viol++;
                @(negedge clk);
            end
            chk("R9 no command during power burst", viol, 0);
            chk("R9 pending after power", {cmd_busy, tail_busy}, 2'b11);
            while (cmd_busy) @(negedge clk);
            chk("R9 tail after command", tail_busy, 1);
            while (tail_busy) @(negedge clk);
            chk("R9 all done", card_clk_run, 0);
        end

        // R10 abort during command and response
        cmd_idx = 6'd18;
        launch(1, 0, 0, 0, 0);
        repeat (10) @(negedge clk);
        pulse_abort();
        chk("R10 command aborted", {cmd_busy, cmd_oe, card_clk_run, cmd_out}, 4'b0001);

        begin
            logic [31:0] keep;
            keep = rsp_word;
            launch(0, 1, 0, 0, 0);
            cmd_in = 1'b0;
            repeat (6) begin
                @(negedge clk);
                cmd_in = 1'($urandom);
            end
            pulse_abort();
            cmd_in = 1'b1;
            chk("R10 response aborted", {rsp_busy, card_clk_run}, 2'b00);
            chk("R10 data kept", rsp_word, keep);
            chk("R10 flags kept", {crc_pass, crc_err, rsp_tmo}, 3'b100);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule